// File: doc/BRIEF.md
# E1 Two-Frame Alignment Framer

This block takes a received E1 bit stream, one bit per clock in which the valid qualifier is high, and locates time slot 0. It then tracks the alternation between frames that carry the frame alignment word and frames that carry the service word. While it hunts for alignment, it compares every incoming bit position against the alignment word. A position becomes a candidate when it matches. The candidate is then confirmed by the service-word marker in the next frame and by a second alignment word one frame later. Once aligned, the block checks each time slot 0. It keeps a saturating count of bad alignment words and drops alignment when bad words run on for too long.

While aligned, the block captures the remote-alarm bit, the five national bits and both international bits. These captures freeze when alignment is lost. A loss-of-alignment flag, a one-cycle loss pulse and an AIS request for the backplane report the alignment status. Control inputs select a loss threshold of three or four, turn off the service-word check, force a fresh hunt, suppress the AIS request, and clear the error count.

Top module: `e1_frame_aligner`

## Requirements
- R1: After reset, `lof` and `ais_en` are 1, while `lof_irq`, `fe_count`, `rx_a`, `rx_sa` and `rx_si` are 0.
- R2: Alignment is gained only after three time slot 0 words in a row: an alignment word, then a word with bit 2 = 1 one frame later, then an alignment word a further frame later. `lof` falls in the cycle after bit 8 of the third word.
- R3: Within time slot 0, the first bit received is bit 1. The alignment word is bits 2..8 = 0,0,1,1,0,1,1 in arrival order. Bit 1 is ignored when comparing.
- R4: While aligned, alignment is lost after consecutive bad alignment words: 3 of them when `loss_thr4` = 0, or 4 when it is 1. A correct word resets the run.
- R5: While aligned, alignment is also lost after 3 (or 4) consecutive service words with bit 2 = 0, unless `nfas_chk_off` = 1. Such words do not change `fe_count`.
- R6: Each bad alignment word seen while aligned adds one to `fe_count`. The count saturates at its maximum. `err_clr` clears it to 0, and a clear takes priority over an increment.
- R7: While `lof` = 1, `fe_count`, `rx_a`, `rx_sa` and `rx_si` hold their values.
- R8: While aligned, each service word updates `rx_a` from bit 3, `rx_sa[4:0]` from bits 4..8 (`rx_sa[4]` from bit 4) and `rx_si[0]` from bit 1. Each alignment word updates `rx_si[1]` from its bit 1.
- R9: `lof_irq` pulses high for exactly one cycle on each transition from aligned to not aligned.
- R10: `ais_en` is 1 exactly when `lof` = 1 and `ais_off` = 0.
- R11: A `force_resync` strobe sends the block to the hunt state in the next cycle. The hunt then restarts on its own and alignment can be regained.
- R12: A candidate that fails its bit-2 confirmation returns the block to hunting. A later valid sequence of three words still aligns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_bit | input | 1 | Received line bit |
| rx_valid | input | 1 | Qualifies `rx_bit` in this cycle |
| loss_thr4 | input | 1 | 1: four bad words to lose alignment; 0: three |
| nfas_chk_off | input | 1 | Disables the service-word bit-2 loss check |
| force_resync | input | 1 | Strobe: drop alignment and hunt again |
| ais_off | input | 1 | Suppresses the AIS request |
| err_clr | input | 1 | Strobe: clear the framing-error count |
| lof | output | 1 | Loss-of-alignment flag |
| lof_irq | output | 1 | One-cycle pulse on loss of alignment |
| ais_en | output | 1 | AIS request toward the backplane |
| fe_count | output | CNT_W | Saturating framing-error count |
| rx_a | output | 1 | Captured remote-alarm bit |
| rx_sa | output | 5 | Captured national bits 4..8 |
| rx_si | output | 2 | Captured international bits (1: alignment frame, 0: service frame) |

## Verification
The assertions assume that `force_resync` and `err_clr` are single-cycle strobes, and that the control levels change only between frames. They also assume that payload bits cannot imitate the alignment word while the block hunts. The stimulus fills all payload with ones. During a hunt it uses only service words with no two adjacent zeros, so the true alignment word is the only match. Strobes are issued in idle cycles with `rx_valid` low. Every check is sampled after a whole frame has been clocked in.

// File: rtl/e1fa_pkg.sv
package e1fa_pkg;

    localparam int unsigned TS0_LAST = 7;
    localparam logic [6:0]  FAS_WORD = 7'b0011011;

    typedef enum logic [1:0] {
        ST_HUNT     = 2'd0,
        ST_CHK_NFAS = 2'd1,
        ST_CHK_FAS  = 2'd2,
        ST_SYNC     = 2'd3
    } align_st_e;

    typedef struct packed {
        align_st_e  st;
        logic [2:0] fas_run;
        logic [2:0] nfas_run;
        logic       fas_frame;
        logic       irq;
    } fsm_regs_t;

    typedef struct packed {
        logic       a;
        logic [4:0] sa;
        logic [1:0] si;
    } cap_regs_t;

endpackage

// File: rtl/e1fa_bit_window.sv
module e1fa_bit_window
    import e1fa_pkg::*;
#(
    parameter int unsigned FRAME_BITS = 256,
    localparam int unsigned POS_W = $clog2(FRAME_BITS)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_bit,
    input  logic       rx_valid,
    input  logic       realign,
    output logic [7:0] win,
    output logic       ts0_end
);

    localparam logic [POS_W-1:0] POS_MAX  = POS_W'(FRAME_BITS - 1);
    localparam logic [POS_W-1:0] POS_TS0E = POS_W'(TS0_LAST);

    typedef struct packed {
        logic [6:0]       sr;
        logic [POS_W-1:0] pos;
    } win_regs_t;

    win_regs_t        q, d;
    logic [POS_W-1:0] cur_pos;

    always_comb begin
        d       = q;
        cur_pos = (q.pos == POS_MAX) ? '0 : q.pos + POS_W'(1);
        win     = {q.sr, rx_bit};
        ts0_end = rx_valid && (cur_pos == POS_TS0E);
        if (rx_valid) begin
            d.sr  = win[6:0];
            d.pos = realign ? POS_TS0E : cur_pos;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R2: a realignment only ever happens on a qualified bit
    assert_realign_on_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        realign |-> rx_valid);

endmodule

// File: rtl/e1fa_align_fsm.sv
module e1fa_align_fsm
    import e1fa_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_valid,
    input  logic [6:0] word,
    input  logic       ts0_end,
    input  logic       loss_thr4,
    input  logic       nfas_chk_off,
    input  logic       force_resync,
    output logic       realign,
    output logic       fas_err,
    output logic       cap_fas,
    output logic       cap_nfas,
    output align_st_e  state,
    output logic       irq
);

    fsm_regs_t  q, d;
    logic [2:0] lim;
    logic       fas_ok;

    always_comb begin
        d        = q;
        d.irq    = 1'b0;
        realign  = 1'b0;
        fas_err  = 1'b0;
        cap_fas  = 1'b0;
        cap_nfas = 1'b0;
        lim      = loss_thr4 ? 3'd4 : 3'd3;
        fas_ok   = (word == FAS_WORD);
        if (force_resync) begin
            d.st       = ST_HUNT;
            d.fas_run  = '0;
            d.nfas_run = '0;
            d.irq      = (q.st == ST_SYNC);
        end else begin
            unique case (q.st)
                ST_HUNT: begin
                    if (rx_valid && fas_ok) begin
                        realign = 1'b1;
                        d.st    = ST_CHK_NFAS;
                    end
                end
                ST_CHK_NFAS: begin
                    if (ts0_end) d.st = word[6] ? ST_CHK_FAS : ST_HUNT;
                end
                ST_CHK_FAS: begin
                    if (ts0_end) begin
                        if (fas_ok) begin
                            d.st        = ST_SYNC;
                            d.fas_frame = 1'b0;
                            d.fas_run   = '0;
                            d.nfas_run  = '0;
                        end else begin
                            d.st = ST_HUNT;
                        end
                    end
                end
                ST_SYNC: begin
                    if (ts0_end) begin
                        d.fas_frame = ~q.fas_frame;
                        if (q.fas_frame) begin
                            cap_fas = 1'b1;
                            if (!fas_ok) begin
                                fas_err   = 1'b1;
                                d.fas_run = q.fas_run + 3'd1;
                            end else begin
                                d.fas_run = '0;
                            end
                        end else begin
                            cap_nfas = 1'b1;
                            if (!word[6] && !nfas_chk_off) d.nfas_run = q.nfas_run + 3'd1;
                            else                           d.nfas_run = '0;
                        end
                        if ((d.fas_run >= lim) || (d.nfas_run >= lim)) begin
                            d.st       = ST_HUNT;
                            d.irq      = 1'b1;
                            d.fas_run  = '0;
                            d.nfas_run = '0;
                        end
                    end
                end
                default: d.st = ST_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_HUNT, fas_run: 3'd0, nfas_run: 3'd0, fas_frame: 1'b0, irq: 1'b0};
        else        q <= d;
    end

    assign state = q.st;
    assign irq   = q.irq;

    assert_irq_leaves_sync_R9: assert property (@(posedge clk) disable iff (!rst_n)
        q.irq |-> (q.st == ST_HUNT) && ($past(q.st) == ST_SYNC));

    assert_sync_via_confirm_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_SYNC) && ($past(q.st) != ST_SYNC) |-> $past(q.st) == ST_CHK_FAS);

    assert_runs_below_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.fas_run < 3'd4) && (q.nfas_run < 3'd4));

    assert_force_hunts_R11: assert property (@(posedge clk) disable iff (!rst_n)
        force_resync |=> q.st == ST_HUNT);

endmodule

// File: rtl/e1fa_err_counter.sv
module e1fa_err_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)                         cnt_d = '0;
        else if (inc && cnt_q != CNT_MAX) cnt_d = cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

    assert_clear_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cnt_q == '0);

    assert_saturates_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX) && !clr |=> cnt_q == CNT_MAX);

endmodule

// File: rtl/e1_frame_aligner.sv
module e1_frame_aligner
    import e1fa_pkg::*;
#(
    parameter int unsigned FRAME_BITS = 256,
    parameter int unsigned CNT_W      = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_bit,
    input  logic             rx_valid,
    input  logic             loss_thr4,
    input  logic             nfas_chk_off,
    input  logic             force_resync,
    input  logic             ais_off,
    input  logic             err_clr,
    output logic             lof,
    output logic             lof_irq,
    output logic             ais_en,
    output logic [CNT_W-1:0] fe_count,
    output logic             rx_a,
    output logic [4:0]       rx_sa,
    output logic [1:0]       rx_si
);

    logic [7:0] win;
    logic       ts0_end, realign, fas_err, cap_fas, cap_nfas;
    align_st_e  state;
    cap_regs_t  cap_q, cap_d;

    e1fa_bit_window #(.FRAME_BITS(FRAME_BITS)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_bit   (rx_bit),
        .rx_valid (rx_valid),
        .realign  (realign),
        .win      (win),
        .ts0_end  (ts0_end)
    );

    e1fa_align_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_valid     (rx_valid),
        .word         (win[6:0]),
        .ts0_end      (ts0_end),
        .loss_thr4    (loss_thr4),
        .nfas_chk_off (nfas_chk_off),
        .force_resync (force_resync),
        .realign      (realign),
        .fas_err      (fas_err),
        .cap_fas      (cap_fas),
        .cap_nfas     (cap_nfas),
        .state        (state),
        .irq          (lof_irq)
    );

    e1fa_err_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (fas_err),
        .clr   (err_clr),
        .cnt   (fe_count)
    );

    always_comb begin
        cap_d = cap_q;
        if (cap_fas) cap_d.si[1] = win[7];
        if (cap_nfas) begin
            cap_d.si[0] = win[7];
            cap_d.a     = win[5];
            cap_d.sa    = win[4:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign lof    = (state != ST_SYNC);
    assign ais_en = lof && !ais_off;
    assign rx_a   = cap_q.a;
    assign rx_sa  = cap_q.sa;
    assign rx_si  = cap_q.si;

    assert_count_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lof && !err_clr |=> $stable(fe_count));

    assert_capture_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lof |=> $stable(cap_q));

    assert_irq_with_loss_R9: assert property (@(posedge clk) disable iff (!rst_n)
        lof_irq |-> lof);

endmodule

// File: tb/e1_frame_aligner_test.sv
`timescale 1ns/1ps
module e1_frame_aligner_test;

    localparam int unsigned FB = 64;
    localparam int unsigned CW = 3;
    localparam int unsigned CMAX = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_bit = 1'b1, rx_valid = 1'b0;
    logic loss_thr4 = 1'b0, nfas_chk_off = 1'b0, force_resync = 1'b0;
    logic ais_off = 1'b0, err_clr = 1'b0;
    logic lof, lof_irq, ais_en, rx_a;
    logic [CW-1:0] fe_count;
    logic [4:0] rx_sa;
    logic [1:0] rx_si;

    int n_chk = 0, n_fail = 0, irq_cnt = 0, exp_cnt = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    e1_frame_aligner #(.FRAME_BITS(FB), .CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .rx_valid(rx_valid),
        .loss_thr4(loss_thr4), .nfas_chk_off(nfas_chk_off),
        .force_resync(force_resync), .ais_off(ais_off), .err_clr(err_clr),
        .lof(lof), .lof_irq(lof_irq), .ais_en(ais_en), .fe_count(fe_count),
        .rx_a(rx_a), .rx_sa(rx_sa), .rx_si(rx_si)
    );

    always @(negedge clk) if (rst_n && lof_irq) irq_cnt++;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send_frame(input logic [7:0] ts0);
        for (int i = 0; i < int'(FB); i++) begin
            @(negedge clk);
            rx_bit   = (i < 8) ? ts0[7 - i] : 1'b1;
            rx_valid = 1'b1;
            @(posedge clk);
            #1 rx_valid = 1'b0;
        end
        #2;
    endtask

    // R3: bits 2..8 of the alignment word, bit 1 free
    function automatic logic [7:0] fas_w(input logic si, input logic bad);
        return bad ? {si, 7'b1011011} : {si, 7'b0011011};
    endfunction

    function automatic logic [7:0] nfas_w(input logic si, input logic b2,
                                          input logic a, input logic [4:0] sa);
        return {si, b2, a, sa};
    endfunction

    task automatic good_nfas(); send_frame(nfas_w(1'b1, 1'b1, 1'b1, 5'b10110)); endtask
    task automatic clean_nfas(); send_frame(nfas_w(1'b0, 1'b1, 1'b0, 5'b11111)); endtask
    task automatic bad_fas(input bit counted);
        send_frame(fas_w(1'b1, 1'b1));
        if (counted && exp_cnt < int'(CMAX)) exp_cnt++;
    endtask

    task automatic strobe_force();
        @(negedge clk); force_resync = 1'b1; @(posedge clk); #1 force_resync = 1'b0; #2;
    endtask
    task automatic strobe_clr();
        @(negedge clk); err_clr = 1'b1; @(posedge clk); #1 err_clr = 1'b0; #2;
    endtask
    task automatic settle_irq(); @(negedge clk); #1; endtask

    task automatic align3(input string req);
        send_frame(fas_w(1'b0, 1'b0));
        check({req, " lof after 1st word"}, lof, 1);
        clean_nfas();
        check({req, " lof after 2nd word"}, lof, 1);
        send_frame(fas_w(1'b1, 1'b0));
        check({req, " lof after 3rd word"}, lof, 0);
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #2;
        // R1 reset state
        check("R1 lof", lof, 1);
        check("R1 ais_en", ais_en, 1);
        check("R1 lof_irq", lof_irq, 0);
        check("R1 fe_count", fe_count, 0);
        check("R1 rx_a", rx_a, 0);
        check("R1 rx_sa", rx_sa, 0);
        check("R1 rx_si", rx_si, 0);

        // R2 / R3 alignment, bit 1 differs between the two alignment words
        align3("R2");
        check("R10 ais_en aligned", ais_en, 0);
        check("R7 no capture before sync", rx_a, 0);

        // R8 captures
        good_nfas();
        check("R8 rx_a", rx_a, 1);
        check("R8 rx_sa", rx_sa, 5'b10110);
        check("R8 rx_si[0]", rx_si[0], 1);
        send_frame(fas_w(1'b1, 1'b0));
        check("R8 rx_si[1]", rx_si[1], 1);
        check("R3 lof with bit1 set", lof, 0);

        // R4 / R6: run reset by a good word
        good_nfas(); bad_fas(1); good_nfas(); bad_fas(1);
        good_nfas(); send_frame(fas_w(1'b0, 1'b0));
        check("R4 run reset lof", lof, 0);
        check("R6 count", fe_count, exp_cnt);
        good_nfas(); bad_fas(1); good_nfas(); bad_fas(1);
        check("R4 two bad lof", lof, 0);
        good_nfas(); bad_fas(1);
        check("R4 three bad lof", lof, 1);
        check("R6 count at loss", fe_count, exp_cnt);
        settle_irq();
        check("R9 irq count", irq_cnt, 1);
        check("R10 ais_en lost", ais_en, 1);

        // R7 frozen while hunting
        clean_nfas(); bad_fas(0);
        check("R7 count frozen", fe_count, exp_cnt);
        check("R7 rx_a held", rx_a, 1);
        check("R7 rx_sa held", rx_sa, 5'b10110);

        // R10 AIS suppression
        ais_off = 1'b1; #1;
        check("R10 ais_off", ais_en, 0);
        ais_off = 1'b0; #1;

        // R6 clear
        strobe_clr(); exp_cnt = 0;
        check("R6 clear", fe_count, 0);

        // R12 failed confirmation, then a valid sequence
        send_frame(fas_w(1'b0, 1'b0));
        send_frame(nfas_w(1'b1, 1'b0, 1'b0, 5'b11111));
        check("R12 lof after failed confirm", lof, 1);
        align3("R12");
        settle_irq();
        check("R12 irq unchanged", irq_cnt, 1);

        // R4 threshold four
        loss_thr4 = 1'b1;
        good_nfas(); bad_fas(1); good_nfas(); bad_fas(1); good_nfas(); bad_fas(1);
        check("R4 thr4 three bad", lof, 0);
        good_nfas(); bad_fas(1);
        check("R4 thr4 four bad", lof, 1);
        check("R6 count thr4", fe_count, exp_cnt);
        settle_irq();
        check("R9 irq count 2", irq_cnt, 2);
        loss_thr4 = 1'b0;

        // R5 service-word errors
        align3("R5");
        send_frame(nfas_w(1'b1, 1'b0, 1'b1, 5'b11111)); send_frame(fas_w(1'b0, 1'b0));
        send_frame(nfas_w(1'b1, 1'b0, 1'b1, 5'b11111)); send_frame(fas_w(1'b0, 1'b0));
        check("R5 two bad service", lof, 0);
        send_frame(nfas_w(1'b1, 1'b0, 1'b1, 5'b11111));
        check("R5 three bad service", lof, 1);
        check("R5 count untouched", fe_count, exp_cnt);
        settle_irq();
        check("R9 irq count 3", irq_cnt, 3);

        // R5 check disabled
        align3("R5b");
        nfas_chk_off = 1'b1;
        for (int k = 0; k < 4; k++) begin
            send_frame(nfas_w(1'b1, 1'b0, 1'b1, 5'b11111));
            send_frame(fas_w(1'b0, 1'b0));
        end
        check("R5 disabled lof", lof, 0);
        nfas_chk_off = 1'b0;

        // R11 forced resync
        strobe_force();
        check("R11 lof after force", lof, 1);
        settle_irq();
        check("R9 irq count 4", irq_cnt, 4);
        align3("R11");

        // R6 saturation
        loss_thr4 = 1'b1;
        for (int k = 0; k < 3; k++) begin
            good_nfas(); bad_fas(1); good_nfas(); bad_fas(1); good_nfas(); bad_fas(1);
            good_nfas(); send_frame(fas_w(1'b0, 1'b0));
        end
        check("R6 saturated", fe_count, int'(CMAX));
        check("R6 model saturated", exp_cnt, int'(CMAX));
        check("R4 still aligned", lof, 0);
        strobe_clr();
        check("R6 clear after saturation", fe_count, 0);

        finished = 1'b1;
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule